// File: doc/BRIEF.md
# Speculative Group Checkpoint: Shadow Register File and Gated Store Queue

This block holds the speculative state of a processor that runs code in translated groups. A working register file is paired with a shadow copy that holds the last committed values. The memory writes of the open group wait in a gated store queue and stay there until the group is closed. Closing a group (commit) does two things: it snapshots the working registers into the shadow copy, and it opens the gate so that the group's stores drain to a valid/ready memory write port. An exception (squash) does the reverse. It reloads the working registers from the shadow copy and throws away every store that has not been released, which returns the architectural state to the last commit point.

The store queue has a fixed number of entries, and this limits how many stores one group can hold. When the queue is full the block raises a flag and refuses further stores, so that the sequencing logic can force a commit or a squash. A group can collect new stores while the previous group's released stores are still draining. A further commit is held off until that drain is complete. Loads look up the queue, so a group reads its own buffered writes.

Top module: `gsb_top`

## Requirements
- R1: A store accepted in the open group never appears on the memory port until a commit has been accepted for that group.
- R2: An accepted commit copies the working registers, as they were before that cycle, into the shadow copy and releases every gated store. A register write or store presented in the commit cycle belongs to the next group.
- R3: A squash reloads the working registers from the shadow copy on the next cycle. It discards every gated store, together with any store or register write presented in the same cycle. Stores already released keep draining.
- R4: After a squash, register reads return the values held at the last commit, and loads no longer hit discarded stores.
- R5: `full_o` is 1 exactly when the queue holds DEPTH entries (default 8). A store presented while full is refused and never stored.
- R6: Released stores leave in program order, one per cycle in which `mem_valid_o` and `mem_ready_i` are both 1. While `mem_ready_i` is 0, the address and data stay stable.
- R7: `commit_rdy_o` is 0 while released stores remain undrained. A commit request in that state is ignored.
- R8: A load whose address matches buffered entries (released or gated) sets `ld_hit_o` and returns the data of the youngest match. With no match, `ld_hit_o` is 0.
- R9: When commit and squash are requested in the same cycle, the squash takes effect and the commit is ignored.
- R10: After reset, all working and shadow registers are 0, the queue is empty, `mem_valid_o` and `full_o` are 0, and `commit_rdy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_we_i | input | 1 | Working register write enable |
| rf_waddr_i | input | $clog2(NREG) | Register write index |
| rf_wdata_i | input | DW | Register write data |
| rf_raddr_i | input | $clog2(NREG) | Register read index |
| rf_rdata_o | output | DW | Working register read data |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| ld_addr_i | input | AW | Load lookup address |
| ld_hit_o | output | 1 | Load matches a buffered store |
| ld_data_o | output | DW | Youngest matching buffered data |
| commit_i | input | 1 | Commit request |
| squash_i | input | 1 | Exception rollback request |
| commit_rdy_o | output | 1 | Commit can be accepted |
| full_o | output | 1 | Store queue full |
| mem_valid_o | output | 1 | Memory write valid |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | DW | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the write |

## Verification
The properties take for granted that register indices stay below NREG and that every control input is a defined 0 or 1 from the first clock after reset. `mem_ready_i` may take any pattern. The stimulus drives all inputs only between clock edges and picks register indices from the populated range. It holds a commit request only while the bench's own model expects it to be accepted or wants it ignored. It also withholds `mem_ready_i` for several cycles so that the port has to keep its data stable under back-pressure.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

    typedef enum logic [1:0] {
        GRP_HOLD   = 2'd0,
        GRP_COMMIT = 2'd1,
        GRP_SQUASH = 2'd2
    } grp_evt_e;

    // squash outranks commit; a commit needs the drain to be idle
    function automatic grp_evt_e resolve_evt(logic commit, logic rdy, logic squash);
        grp_evt_e e;
        if (squash)
            e = GRP_SQUASH;
        else if (commit && rdy)
            e = GRP_COMMIT;
        else
            e = GRP_HOLD;
        return e;
    endfunction

endpackage

// File: rtl/gsb_shadow_rf.sv
module gsb_shadow_rf
    import gsb_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  grp_evt_e       evt,
    input  logic           we,
    input  logic [RAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] work;
        logic [NREG-1:0][DW-1:0] shad;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (evt)
            GRP_SQUASH: begin
                st_d.work = st_q.shad;
            end
            GRP_COMMIT: begin
                st_d.shad = st_q.work;
                if (we) st_d.work[waddr] = wdata;
            end
            default: begin
                if (we) st_d.work[waddr] = wdata;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.work[raddr];

endmodule

// File: rtl/gsb_store_q.sv
module gsb_store_q
    import gsb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  grp_evt_e      evt,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          commit_rdy,
    output logic          full,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ready,
    output logic [CW-1:0] rel_cnt,
    output logic [CW-1:0] gate_cnt
);

    // DEPTH is a power of two so the index wraps naturally
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [IW-1:0]            head;
        logic [CW-1:0]            rel;
        logic [CW-1:0]            gate;
    } sq_t;

    sq_t st_d, st_q;

    logic [CW-1:0] occ;
    logic [IW-1:0] tail;
    logic          accept;
    logic          drain;

    assign occ    = st_q.rel + st_q.gate;
    assign full   = (occ == CW'(DEPTH));
    assign tail   = st_q.head + IW'(occ);
    assign accept = st_valid && (evt != GRP_SQUASH) && !full;
    assign drain  = (st_q.rel != '0) && mem_ready;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.addr[tail] = st_addr;
            st_d.data[tail] = st_data;
        end
        st_d.head = st_q.head + IW'(drain);
        st_d.rel  = st_q.rel - CW'(drain);
        unique case (evt)
            GRP_COMMIT: begin
                st_d.rel  = st_q.gate;
                st_d.gate = CW'(accept);
            end
            GRP_SQUASH: begin
                st_d.gate = '0;
            end
            default: begin
                st_d.gate = st_q.gate + CW'(accept);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // oldest to youngest: a later match overrides an earlier one
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((i < int'(occ)) && (st_q.addr[st_q.head + IW'(i)] == ld_addr)) begin
                ld_hit  = 1'b1;
                ld_data = st_q.data[st_q.head + IW'(i)];
            end
        end
    end

    assign commit_rdy = (st_q.rel == '0);
    assign mem_valid  = (st_q.rel != '0);
    assign mem_addr   = st_q.addr[st_q.head];
    assign mem_data   = st_q.data[st_q.head];
    assign rel_cnt    = st_q.rel;
    assign gate_cnt   = st_q.gate;

endmodule

// File: rtl/gsb_top.sv
module gsb_top
    import gsb_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int RAW  = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rf_we_i,
    input  logic [RAW-1:0] rf_waddr_i,
    input  logic [DW-1:0]  rf_wdata_i,
    input  logic [RAW-1:0] rf_raddr_i,
    output logic [DW-1:0]  rf_rdata_o,
    input  logic           st_valid_i,
    input  logic [AW-1:0]  st_addr_i,
    input  logic [DW-1:0]  st_data_i,
    input  logic [AW-1:0]  ld_addr_i,
    output logic           ld_hit_o,
    output logic [DW-1:0]  ld_data_o,
    input  logic           commit_i,
    input  logic           squash_i,
    output logic           commit_rdy_o,
    output logic           full_o,
    output logic           mem_valid_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_data_o,
    input  logic           mem_ready_i
);

    grp_evt_e      evt;
    logic [CW-1:0] sq_rel;
    logic [CW-1:0] sq_gate;

    assign evt = resolve_evt(commit_i, commit_rdy_o, squash_i);

    gsb_shadow_rf #(.NREG(NREG), .DW(DW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .we    (rf_we_i),
        .waddr (rf_waddr_i),
        .wdata (rf_wdata_i),
        .raddr (rf_raddr_i),
        .rdata (rf_rdata_o)
    );

    gsb_store_q #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .st_valid   (st_valid_i),
        .st_addr    (st_addr_i),
        .st_data    (st_data_i),
        .ld_addr    (ld_addr_i),
        .ld_hit     (ld_hit_o),
        .ld_data    (ld_data_o),
        .commit_rdy (commit_rdy_o),
        .full       (full_o),
        .mem_valid  (mem_valid_o),
        .mem_addr   (mem_addr_o),
        .mem_data   (mem_data_o),
        .mem_ready  (mem_ready_i),
        .rel_cnt    (sq_rel),
        .gate_cnt   (sq_gate)
    );

endmodule

// File: rtl/gsb_chk.sv
module gsb_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          commit_i,
    input logic          squash_i,
    input logic          commit_rdy,
    input logic          full,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic [CW-1:0] rel_cnt,
    input logic [CW-1:0] gate_cnt
);

    logic [CW:0] occ;
    assign occ = rel_cnt + gate_cnt;

    a_r1_release_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_i && commit_rdy && !squash_i) |=> rel_cnt <= $past(rel_cnt));

    a_r3_squash_clears_group: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> gate_cnt == '0);

    a_r5_refused_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full && !commit_i && !squash_i |=> occ <= $past(occ));

    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (CW+1)'(DEPTH));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    a_r7_commit_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_rdy && !squash_i |=> gate_cnt >= $past(gate_cnt));

    a_r9_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && squash_i |=> rel_cnt <= $past(rel_cnt));

endmodule

bind gsb_top gsb_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit_i),
    .squash_i   (squash_i),
    .commit_rdy (commit_rdy_o),
    .full       (full_o),
    .mem_valid  (mem_valid_o),
    .mem_ready  (mem_ready_i),
    .mem_addr   (mem_addr_o),
    .mem_data   (mem_data_o),
    .rel_cnt    (sq_rel),
    .gate_cnt   (sq_gate)
);

// File: tb/sim_gsb_top.sv
`timescale 1ns/1ps
module sim_gsb_top;

    localparam int NREG = 8, DW = 32, AW = 16, DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rf_we_i = 0; logic [2:0] rf_waddr_i = 0; logic [DW-1:0] rf_wdata_i = 0;
    logic [2:0] rf_raddr_i = 0; logic [DW-1:0] rf_rdata_o;
    logic st_valid_i = 0; logic [AW-1:0] st_addr_i = 0; logic [DW-1:0] st_data_i = 0;
    logic [AW-1:0] ld_addr_i = 0; logic ld_hit_o; logic [DW-1:0] ld_data_o;
    logic commit_i = 0, squash_i = 0, commit_rdy_o, full_o;
    logic mem_valid_o; logic [AW-1:0] mem_addr_o; logic [DW-1:0] mem_data_o;
    logic mem_ready_i = 0;

    int n_chk = 0, n_fail = 0;
    logic [AW+DW-1:0] gate_q[$];
    logic [AW+DW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    gsb_top #(.NREG(NREG), .DW(DW), .AW(AW), .DEPTH(DEPTH)) u0 (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        st_valid_i = 0; commit_i = 0; squash_i = 0; rf_we_i = 0;
    endtask

    // driver side of the scoreboard
    task automatic store(logic [AW-1:0] a, logic [DW-1:0] d);
        st_valid_i = 1; st_addr_i = a; st_data_i = d;
        if (gate_q.size() + exp_q.size() < DEPTH) gate_q.push_back({a, d});
    endtask

    task automatic model_commit();
        foreach (gate_q[i]) exp_q.push_back(gate_q[i]);
        gate_q.delete();
    endtask

    task automatic wreg(int r, logic [DW-1:0] v);
        rf_we_i = 1; rf_waddr_i = 3'(r); rf_wdata_i = v;
    endtask

    task automatic rreg(string tag, int r, logic [DW-1:0] v);
        rf_raddr_i = 3'(r); #0.2;
        check(tag, 64'(rf_rdata_o), 64'(v));
    endtask

    task automatic load(string tag, logic [AW-1:0] a, logic hit, logic [DW-1:0] d);
        ld_addr_i = a; #0.2;
        check(tag, 64'(ld_hit_o), 64'(hit));
        if (hit) check(tag, 64'(ld_data_o), 64'(d));
    endtask

    // monitor side: a handshake seen at the falling edge completes at the next rising edge
    always @(negedge clk) begin
        if (rst_n && mem_valid_o && mem_ready_i) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected write actual=%0h_%0h expected=none", mem_addr_o, mem_data_o);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                if ({mem_addr_o, mem_data_o} !== e) begin
                    n_fail++;
                    $display("FAIL R6 order actual=%0h_%0h expected=%0h", mem_addr_o, mem_data_o, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10 reset state
        check("R10 mem_valid", 64'(mem_valid_o), 0);
        check("R10 full", 64'(full_o), 0);
        check("R10 commit_rdy", 64'(commit_rdy_o), 1);
        rreg("R10 reg", 5, 0);
        load("R10 load", 16'h0010, 0, 0);

        // open group: registers and three stores
        wreg(1, 32'd11); store(16'h0010, 32'hA1); tick();
        wreg(2, 32'd22); store(16'h0014, 32'hB2); tick();
        store(16'h0010, 32'hC3); mem_ready_i = 1; tick();
        repeat (3) begin
            check("R1 gated", 64'(mem_valid_o), 0);
            tick();
        end
        load("R8 youngest", 16'h0010, 1, 32'hC3);
        load("R8 other", 16'h0014, 1, 32'hB2);
        load("R8 miss", 16'h0020, 0, 0);

        // commit with a same-cycle store and register write (R2)
        mem_ready_i = 0;
        commit_i = 1; model_commit(); store(16'h0030, 32'hD4); wreg(3, 32'd33); tick();
        check("R6 head valid", 64'(mem_valid_o), 1);
        check("R6 head addr", 64'(mem_addr_o), 64'h0010);
        check("R7 rdy low", 64'(commit_rdy_o), 0);
        commit_i = 1; tick();       // ignored (R7)
        repeat (2) begin
            check("R6 stable addr", 64'(mem_addr_o), 64'h0010);
            check("R6 stable data", 64'(mem_data_o), 64'hA1);
            tick();
        end
        mem_ready_i = 1;
        while (!commit_rdy_o) tick();
        repeat (3) begin
            check("R7 ignored commit", 64'(mem_valid_o), 0);
            tick();
        end
        load("R2 new group", 16'h0030, 1, 32'hD4);

        // squash with same-cycle store and write (R3, R4)
        wreg(1, 32'd99); tick();
        rreg("R3 working", 1, 32'd99);
        squash_i = 1; st_valid_i = 1; st_addr_i = 16'h0040; st_data_i = 32'hE5;
        wreg(2, 32'd77); gate_q.delete(); tick();
        rreg("R4 r1", 1, 32'd11);
        rreg("R4 r2", 2, 32'd22);
        rreg("R2 commit-cycle write", 3, 32'd0);
        load("R4 dropped", 16'h0030, 0, 0);
        load("R3 same-cycle store", 16'h0040, 0, 0);

        // commit and squash together (R9)
        store(16'h0050, 32'hF6); wreg(3, 32'd5); tick();
        commit_i = 1; squash_i = 1; gate_q.delete(); tick();
        rreg("R9 r3", 3, 32'd0);
        load("R9 store", 16'h0050, 0, 0);
        repeat (3) begin
            check("R9 no release", 64'(mem_valid_o), 0);
            tick();
        end

        // fill the queue (R5)
        mem_ready_i = 0;
        for (int i = 0; i < DEPTH; i++) begin
            store(16'h0100 + 16'(i * 4), 32'h100 + 32'(i)); tick();
        end
        check("R5 full", 64'(full_o), 1);
        store(16'h0200, 32'h999); tick();
        load("R5 refused", 16'h0200, 0, 0);
        check("R5 still full", 64'(full_o), 1);
        commit_i = 1; model_commit(); tick();
        mem_ready_i = 1;
        while (!commit_rdy_o) tick();
        tick(); tick();
        check("R5 empty", 64'(full_o), 0);
        check("R6 all drained", 64'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule